// File: doc/BRIEF.md
# Byte FIFO with Trigger-Level Flag

This block is the byte store that sits between a flash controller's register port and its serial engine. Two sources can add bytes: the CPU, through writes to the data port, and the serial engine, when it receives a byte. Two sinks can remove bytes: the serial engine, when it needs the next byte to transmit, and the CPU, through reads of the data port. The oldest byte is always shown on the head output, so a pop takes effect on the next clock edge.

Software sees the number of bytes held through a count register. Any write to that register empties the store. A transfer-start pulse also empties it, unless a keep option is set. The keep option lets bytes loaded before a full-duplex transfer survive the start.

A 2-bit trigger code selects a threshold of 1, 2, 4 or 8 bytes. The read-ready flag is raised while the fill count is at or above that threshold. A room flag tells the transmitter side that one more byte fits.

Top module: `bfifo_trig`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has count 0, `empty` 1, `full` 0, `wr_room` 1 and `rd_ready` 0.
- R2: Bytes leave in the order they were accepted, and `head_data` shows the oldest held byte whenever the count is non-zero.
- R3: `count_o` holds the number of stored bytes, from 0 to DEPTH (8 by default). It changes one clock edge after an accepted push or pop.
- R4: A push while the store is full, with no pop in the same cycle, is dropped. The count and the contents stay unchanged.
- R5: A pop while the store is empty is ignored, and the count stays 0.
- R6: When the store is non-empty, a push and a pop in the same cycle both take effect and the count is unchanged. This also holds when the store is full.
- R7: When both sources push in one cycle, the engine byte (`eng_rx_data`) is stored and the CPU byte is dropped. When both sinks pop in one cycle, only one byte is removed.
- R8: A cycle with `ptr_wr_en` high empties the store at the next edge, whatever push or pop is requested in that cycle.
- R9: A `xfer_start` pulse with `keep_fifo` low empties the store. With `keep_fifo` high, the count and contents are left as they are.
- R10: `rd_ready` is high exactly when the count is at least the threshold chosen by `trig_sel`: code 0 gives 1 byte, 1 gives 2, 2 gives 4 and 3 gives 8.
- R11: `full` is high exactly when the count equals DEPTH, `empty` exactly when it is 0, and `wr_room` is the inverse of `full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | CPU write to the data port (push) |
| cpu_wr_data | input | 8 | Byte written by the CPU |
| cpu_rd_en | input | 1 | CPU read of the data port (pop) |
| eng_rx_valid | input | 1 | Serial engine delivers a received byte (push) |
| eng_rx_data | input | 8 | Received byte |
| eng_tx_pop | input | 1 | Serial engine takes the next byte to send (pop) |
| ptr_wr_en | input | 1 | Write to the count register; empties the store |
| xfer_start | input | 1 | Start of a new serial transfer |
| keep_fifo | input | 1 | Suppresses the flush on transfer start |
| trig_sel | input | 2 | Read-ready threshold code |
| count_o | output | 4 | Number of bytes held |
| head_data | output | 8 | Oldest held byte |
| rd_ready | output | 1 | Count has reached the threshold |
| wr_room | output | 1 | At least one free entry |
| empty | output | 1 | No bytes held |
| full | output | 1 | All entries held |

## Verification
The bench builds the block with the default DEPTH of 8. At this depth the largest trigger threshold equals the capacity, so code 3 asserts `rd_ready` only in the full state. The full state is also where push-while-full and push-with-pop are exercised, so all four trigger codes meet both edges of the count range. With 8 entries, the pointers wrap after a short run, so ordering across the wrap is checked by draining a store that was filled, popped and refilled.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;

    parameter int BYTE_W = 8;

    // Which source a push came from.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CPU  = 2'd1,
        SRC_ENG  = 2'd2
    } push_src_e;

    // One cycle of merged requests presented to the storage.
    typedef struct packed {
        logic              push;
        logic              pop;
        logic              flush;
        push_src_e         src;
        logic [BYTE_W-1:0] wdata;
    } fifo_op_t;

    // Threshold for a trigger code: 1 << code, clamped to the depth.
    function automatic int unsigned trig_level(input logic [1:0] code,
                                               input int unsigned depth);
        int unsigned lvl;
        lvl = 32'd1 << code;
        if (lvl > depth) lvl = depth;
        return lvl;
    endfunction

endpackage

// File: rtl/bfifo_arb.sv
module bfifo_arb
    import bfifo_pkg::*;
(
    input  logic              cpu_wr_en,
    input  logic [BYTE_W-1:0] cpu_wr_data,
    input  logic              cpu_rd_en,
    input  logic              eng_rx_valid,
    input  logic [BYTE_W-1:0] eng_rx_data,
    input  logic              eng_tx_pop,
    input  logic              ptr_wr_en,
    input  logic              xfer_start,
    input  logic              keep_fifo,
    output fifo_op_t          op
);

    always_comb begin
        op       = '0;
        op.src   = SRC_NONE;
        // Engine receive path has priority over the CPU data port.
        if (eng_rx_valid) begin
            op.push  = 1'b1;
            op.src   = SRC_ENG;
            op.wdata = eng_rx_data;
        end else if (cpu_wr_en) begin
            op.push  = 1'b1;
            op.src   = SRC_CPU;
            op.wdata = cpu_wr_data;
        end
        // Either sink removes a single byte per cycle.
        op.pop   = eng_tx_pop | cpu_rd_en;
        op.flush = ptr_wr_en | (xfer_start & ~keep_fifo);
    end

endmodule

// File: rtl/bfifo_store.sv
module bfifo_store
    import bfifo_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  fifo_op_t          op,
    output logic [CNT_W-1:0]  count,
    output logic [BYTE_W-1:0] head
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              do_pop;
    logic              do_push;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
    endfunction

    assign do_pop  = op.pop && (count != '0);
    assign do_push = op.push && ((count != CNT_FULL) || do_pop);

    always_ff @(posedge clk) begin
        if (rst || op.flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (do_push && !op.flush) begin
            for (int i = 0; i < DEPTH; i++)
                if (wr_ptr == PTR_W'(i)) mem[i] <= op.wdata;
        end
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/bfifo_flags.sv
module bfifo_flags
    import bfifo_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       trig_sel,
    output logic             rd_ready,
    output logic             wr_room,
    output logic             empty,
    output logic             full
);

    logic [CNT_W-1:0] lvl_tab [4];

    // One precomputed threshold per trigger code.
    for (genvar g = 0; g < 4; g++) begin : g_lvl
        assign lvl_tab[g] = CNT_W'(trig_level(2'(g), DEPTH));
    end

    assign rd_ready = (count >= lvl_tab[trig_sel]);
    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);
    assign wr_room  = ~full;

endmodule

// File: rtl/bfifo_trig.sv
module bfifo_trig
    import bfifo_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr_en,
    input  logic [BYTE_W-1:0] cpu_wr_data,
    input  logic              cpu_rd_en,
    input  logic              eng_rx_valid,
    input  logic [BYTE_W-1:0] eng_rx_data,
    input  logic              eng_tx_pop,
    input  logic              ptr_wr_en,
    input  logic              xfer_start,
    input  logic              keep_fifo,
    input  logic [1:0]        trig_sel,
    output logic [CNT_W-1:0]  count_o,
    output logic [BYTE_W-1:0] head_data,
    output logic              rd_ready,
    output logic              wr_room,
    output logic              empty,
    output logic              full
);

    fifo_op_t op;

    bfifo_arb u_arb (
        .cpu_wr_en    (cpu_wr_en),
        .cpu_wr_data  (cpu_wr_data),
        .cpu_rd_en    (cpu_rd_en),
        .eng_rx_valid (eng_rx_valid),
        .eng_rx_data  (eng_rx_data),
        .eng_tx_pop   (eng_tx_pop),
        .ptr_wr_en    (ptr_wr_en),
        .xfer_start   (xfer_start),
        .keep_fifo    (keep_fifo),
        .op           (op)
    );

    bfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .count (count_o),
        .head  (head_data)
    );

    bfifo_flags #(.DEPTH(DEPTH)) u_flags (
        .count    (count_o),
        .trig_sel (trig_sel),
        .rd_ready (rd_ready),
        .wr_room  (wr_room),
        .empty    (empty),
        .full     (full)
    );

endmodule

// File: rtl/bfifo_trig_chk.sv
module bfifo_trig_chk #(
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_wr_en,
    input logic             cpu_rd_en,
    input logic             eng_rx_valid,
    input logic             eng_tx_pop,
    input logic             ptr_wr_en,
    input logic             xfer_start,
    input logic             keep_fifo,
    input logic [1:0]       trig_sel,
    input logic [CNT_W-1:0] count_o,
    input logic             rd_ready,
    input logic             wr_room,
    input logic             empty,
    input logic             full
);

    logic any_push, any_pop, any_flush;
    int unsigned exp_lvl;

    assign any_push  = cpu_wr_en | eng_rx_valid;
    assign any_pop   = cpu_rd_en | eng_tx_pop;
    assign any_flush = ptr_wr_en | (xfer_start & ~keep_fifo);

    always_comb begin
        case (trig_sel)
            2'd0:    exp_lvl = 1;
            2'd1:    exp_lvl = 2;
            2'd2:    exp_lvl = 4;
            default: exp_lvl = 8;
        endcase
        if (exp_lvl > DEPTH) exp_lvl = DEPTH;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (count_o == '0)); // R1
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst) int'(count_o) <= DEPTH); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (int'(count_o) == DEPTH && any_push && !any_pop && !any_flush) |=> (int'(count_o) == DEPTH)); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (count_o == '0 && any_pop && !any_push && !any_flush) |=> (count_o == '0)); // R5
    AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (count_o != '0 && any_push && any_pop && !any_flush) |=> $stable(count_o)); // R6
    AST_PTR_FLUSH: assert property (@(posedge clk) disable iff (rst) ptr_wr_en |=> (count_o == '0)); // R8
    AST_START_KEEP: assert property (@(posedge clk) disable iff (rst)
        (xfer_start && keep_fifo && !ptr_wr_en && !any_push && !any_pop) |=> $stable(count_o)); // R9
    AST_TRIG_FLAG: assert property (@(posedge clk) disable iff (rst)
        rd_ready == (int'(count_o) >= exp_lvl)); // R10
    AST_FULL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (full == (int'(count_o) == DEPTH)) && (empty == (count_o == '0)) && (wr_room != full)); // R11

endmodule

bind bfifo_trig bfifo_trig_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_wr_en    (cpu_wr_en),
    .cpu_rd_en    (cpu_rd_en),
    .eng_rx_valid (eng_rx_valid),
    .eng_tx_pop   (eng_tx_pop),
    .ptr_wr_en    (ptr_wr_en),
    .xfer_start   (xfer_start),
    .keep_fifo    (keep_fifo),
    .trig_sel     (trig_sel),
    .count_o      (count_o),
    .rd_ready     (rd_ready),
    .wr_room      (wr_room),
    .empty        (empty),
    .full         (full)
);

// File: tb/bfifo_trig_test.sv
module bfifo_trig_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       cpu_wr_en, cpu_rd_en, eng_rx_valid, eng_tx_pop;
    logic       ptr_wr_en, xfer_start, keep_fifo;
    logic [7:0] cpu_wr_data, eng_rx_data;
    logic [1:0] trig_sel;
    logic [3:0] count_o;
    logic [7:0] head_data;
    logic       rd_ready, wr_room, empty, full;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    bfifo_trig #(.DEPTH(8)) uut (
        .clk(clk), .rst(rst),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data), .cpu_rd_en(cpu_rd_en),
        .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data), .eng_tx_pop(eng_tx_pop),
        .ptr_wr_en(ptr_wr_en), .xfer_start(xfer_start), .keep_fifo(keep_fifo),
        .trig_sel(trig_sel), .count_o(count_o), .head_data(head_data),
        .rd_ready(rd_ready), .wr_room(wr_room), .empty(empty), .full(full)
    );

    // Row: ops, trigger code, cpu data (engine data is its inverse), expected count/head/ready.
    typedef struct packed {
        logic       cw, ep, cr, eo;
        logic [1:0] trig;
        logic [7:0] d;
        logic [3:0] cnt;
        logic       hchk;
        logic [7:0] head;
        logic       rdy;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b1,1'b0,1'b0,1'b0,2'd0,8'hA1,4'd1,1'b1,8'hA1,1'b1}, // R3 cpu push
        '{1'b0,1'b1,1'b0,1'b0,2'd1,8'hB2,4'd2,1'b1,8'hA1,1'b1}, // R3 engine push 4D
        '{1'b1,1'b1,1'b0,1'b0,2'd2,8'h33,4'd3,1'b1,8'hA1,1'b0}, // R7 engine CC wins
        '{1'b0,1'b0,1'b1,1'b0,2'd1,8'h00,4'd2,1'b1,8'h4D,1'b1}, // R2 cpu pop
        '{1'b1,1'b0,1'b0,1'b1,2'd2,8'h11,4'd2,1'b1,8'hCC,1'b0}, // R6 push+pop
        '{1'b0,1'b0,1'b1,1'b1,2'd0,8'h00,4'd1,1'b1,8'h11,1'b1}, // R7 dual pop removes one
        '{1'b0,1'b0,1'b1,1'b0,2'd0,8'h00,4'd0,1'b0,8'h00,1'b0}, // R3 drain
        '{1'b0,1'b0,1'b0,1'b1,2'd0,8'h00,4'd0,1'b0,8'h00,1'b0}  // R5 pop on empty
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        cpu_wr_en = 0; cpu_rd_en = 0; eng_rx_valid = 0; eng_tx_pop = 0;
        ptr_wr_en = 0; xfer_start = 0; keep_fifo = 0; rst = 0;
    endtask

    // Inputs are applied at a falling edge, one rising edge passes, results read at the next falling edge.
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic push_cpu(input logic [7:0] d);
        cpu_wr_en = 1; cpu_wr_data = d; step();
    endtask

    initial begin
        idle();
        cpu_wr_data = 0; eng_rx_data = 0; trig_sel = 0;
        rst = 1;
        @(negedge clk); @(negedge clk);
        idle();
        // R1 reset state
        chk("R1", "count", count_o, 0);
        chk("R1", "empty", empty, 1);
        chk("R1", "full", full, 0);
        chk("R1", "wr_room", wr_room, 1);
        chk("R1", "rd_ready", rd_ready, 0);

        for (int i = 0; i < 8; i++) begin
            cpu_wr_en = VEC[i].cw; eng_rx_valid = VEC[i].ep;
            cpu_rd_en = VEC[i].cr; eng_tx_pop = VEC[i].eo;
            trig_sel = VEC[i].trig; cpu_wr_data = VEC[i].d; eng_rx_data = ~VEC[i].d;
            step();
            chk("R3", "vector count", count_o, VEC[i].cnt);
            if (VEC[i].hchk) chk("R2", "vector head", head_data, VEC[i].head);
            chk("R10", "vector rd_ready", rd_ready, VEC[i].rdy);
            chk("R11", "vector empty", empty, VEC[i].cnt == 0);
        end

        // Fill to full across a pointer wrap; watch trigger code 2 and 3.
        for (int i = 0; i < 8; i++) begin
            trig_sel = 2'd2;
            push_cpu(8'h50 + 8'(i));
            chk("R3", "fill count", count_o, i + 1);
            chk("R10", "code2 rd_ready", rd_ready, (i + 1) >= 4);
        end
        trig_sel = 2'd3;
        #1;
        chk("R10", "code3 full rd_ready", rd_ready, 1);
        chk("R11", "full", full, 1);
        chk("R11", "wr_room at full", wr_room, 0);
        // R4 push while full dropped
        push_cpu(8'hEE);
        chk("R4", "count after full push", count_o, 8);
        chk("R4", "head after full push", head_data, 8'h50);
        // R6 push with pop at full
        eng_rx_valid = 1; eng_rx_data = 8'h77; cpu_rd_en = 1; step();
        chk("R6", "count push+pop full", count_o, 8);
        chk("R10", "code3 after push+pop", rd_ready, 1);
        // R2 drain order
        for (int i = 0; i < 8; i++) begin
            chk("R2", "drain head", head_data, (i < 7) ? (8'h51 + 8'(i)) : 8'h77);
            eng_tx_pop = 1; step();
        end
        chk("R5", "drained count", count_o, 0);
        trig_sel = 2'd3;
        #1;
        chk("R10", "code3 empty rd_ready", rd_ready, 0);

        // R8 count-register write flush wins over a push
        push_cpu(8'h01); push_cpu(8'h02); push_cpu(8'h03);
        ptr_wr_en = 1; cpu_wr_en = 1; cpu_wr_data = 8'h04; step();
        chk("R8", "count after ptr write", count_o, 0);

        // R9 transfer start with and without keep
        push_cpu(8'h21); push_cpu(8'h22);
        xfer_start = 1; keep_fifo = 1; step();
        chk("R9", "kept count", count_o, 2);
        chk("R9", "kept head", head_data, 8'h21);
        xfer_start = 1; keep_fifo = 0; step();
        chk("R9", "auto-flush count", count_o, 0);

        // R1 reset mid-run
        push_cpu(8'h99);
        rst = 1; step();
        chk("R1", "count after reset", count_o, 0);

        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 5000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule